// File: doc/BRIEF.md
# Dual-Table Transmit Byte-Count Sequencer

This block steers the transmit side of one serial line through two buffer descriptors, a principal one and an alternate one. Each descriptor holds an 18-bit current address and a 16-bit byte count. The low 15 bits of the count hold the negated number of bytes still to send. Bit 15 is a mark flag. A host loads the descriptors and a control word through a small write port. The sequencer asks memory for the control byte of the character at the active address and then offers the line either an escape character, the data character, idle sync or a steady mark level. Each time a data character leaves, the address and count of the active descriptor advance.

When the active count wraps to zero, the sequencer moves to the other descriptor. If that descriptor is also empty, it stops. If the expiring count was marked, a new transmit mode is taken from a staging field, and a send-check-next flag can be raised so that the block-check logic inserts its bytes. Memory access, serialization and the check computation are outside the block. Memory reports its errors back on two strobes.

Top module: `txseq_top`

## Requirements
- R1: After reset, go, use-alternate, send-check-next, both error flags and the transmit mode read 0, fetch_req is low and tx_kind is 0 (idle sync).
- R2: Host writes select a register by wr_sel: 0 principal address, 1 principal count, 2 alternate address, 3 alternate count, 4 control, 5 mode, 6 escape character, 7 ignored. An address write loads {wr_ext, wr_data}. fetch_addr always shows the address of the active table.
- R3: Each data character taken (tx_ready while tx_kind is 3) advances the active address by one and the low 15 bits of the active count by one. Bit 15 of the count is left unchanged.
- R4: The table is chosen by the use-alternate flag (control bit 1: 0 principal, 1 alternate). When the principal count wraps to zero the flag becomes 1, and when the alternate count wraps to zero it becomes 0. Fetching continues from the other table while go (control bit 0) is still set.
- R5: When a count expires and the other count is zero, or when go is found set with both counts zero, go clears and the sequencer idles. tx_kind is then 1 (mark) if idle-mark (control bit 2) is set, else 0 (sync).
- R6: When a marked count (bit 15 = 0) expires, the mode register takes the next-mode field (control bits 6:4). If check-enable (control bit 3) is set, send_chk1 rises. When a normal count (bit 15 = 1) expires, neither the mode nor send_chk1 changes.
- R7: A character whose control byte has bit 3 set raises send_chk1 when it is taken. A chk_taken pulse clears send_chk1.
- R8: A character whose control byte has bit 1 set is preceded by the escape character: tx_kind is 2 and esc_char holds the stored byte. Taking the escape character does not move the descriptor.
- R9: If the host clears go while the sequencer waits for a control byte, fetch_req drops on the next cycle. If go is cleared during an escape or data character, that character completes and advances the descriptor, and no further fetch follows.
- R10: mem_nxm and mem_perr each set their own sticky status flag and clear go. Any control write clears both flags.
- R11: If go is set while the active count is zero and the other count is not, the sequencer switches tables and transmits from the other one.
- R12: tx_ready while no escape or data character is offered leaves the descriptors unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| wr_ext | input | 2 | Upper address bits for address writes |
| ctl_valid | input | 1 | Control byte for the fetched character is present |
| ctl_byte | input | 8 | Control byte of the fetched character |
| tx_ready | input | 1 | Line takes the offered character this cycle |
| chk_taken | input | 1 | Check logic has taken the send-check-next request |
| mem_nxm | input | 1 | Memory reported a missing address |
| mem_perr | input | 1 | Memory reported a parity error |
| fetch_req | output | 1 | Control byte and character at fetch_addr are wanted |
| fetch_addr | output | 18 | Current address of the active table |
| tx_kind | output | 2 | Offered item: 0 sync, 1 mark, 2 escape, 3 data |
| esc_char | output | 8 | Stored escape character |
| tx_mode | output | 3 | Active transmit mode |
| send_chk1 | output | 1 | First check byte goes next |
| go | output | 1 | Transmission enabled |
| use_alt | output | 1 | Alternate table active |
| err_nxm | output | 1 | Sticky missing-address flag |
| err_perr | output | 1 | Sticky parity flag |

## Verification
The hardest case to reach is the expiry of a marked count while check insertion is enabled and the table changes over. In that case mode, flag, table and go all move on the same edge. The stimulus loads a two-character marked principal count, a one-character normal alternate count, a distinct mode and a staging field. It then walks the principal table dry, so the marked expiry can be compared with the normal one that follows. An abort that lands in the same cycle as a data hand-off is produced by driving the control write and tx_ready together.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_ESC   = 2'd2,
    ST_DATA  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    K_SYNC = 2'd0,
    K_MARK = 2'd1,
    K_ESC  = 2'd2,
    K_DATA = 2'd3
  } line_kind_t;

  localparam logic [2:0] SEL_PADDR = 3'd0;
  localparam logic [2:0] SEL_PCNT  = 3'd1;
  localparam logic [2:0] SEL_AADDR = 3'd2;
  localparam logic [2:0] SEL_ACNT  = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;
  localparam logic [2:0] SEL_MODE  = 3'd5;
  localparam logic [2:0] SEL_ESC   = 3'd6;
endpackage

// File: rtl/txseq_desc.sv
module txseq_desc #(
  parameter int ADDR_W = 18,
  parameter int EXT_W  = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [EXT_W-1:0]  wr_ext,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr_o,
  output logic              zero_o,
  output logic              last_o,
  output logic              normal_o
);
  localparam int LOW_W = ADDR_W - EXT_W;
  localparam int FLD_W = CNT_W - 1;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              en;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (adv) begin
      addr_d = addr_q + ADDR_W'(1);
      cnt_d  = {cnt_q[CNT_W-1], cnt_q[FLD_W-1:0] + FLD_W'(1)};
    end
    if (wr_addr) addr_d = {wr_ext, wr_data[LOW_W-1:0]};
    if (wr_cnt)  cnt_d  = wr_data[CNT_W-1:0];
  end

  assign en = adv | wr_addr | wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_o   = addr_q;
  assign zero_o   = (cnt_q[FLD_W-1:0] == '0);
  assign last_o   = &cnt_q[FLD_W-1:0];
  assign normal_o = cnt_q[CNT_W-1];

  // R3: one step of the count field per character, mark bit kept
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !wr_cnt |=> (cnt_q[FLD_W-1:0] == $past(cnt_q[FLD_W-1:0]) + FLD_W'(1))
                       && (cnt_q[CNT_W-1] == $past(cnt_q[CNT_W-1])));
endmodule

// File: rtl/txseq_fsm.sv
module txseq_fsm
  import txseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       act_zero,
  input  logic       ctl_valid,
  input  logic       ctl_esc,
  input  logic       tx_ready,
  output seq_state_t state_o,
  output logic       fetch_req,
  output logic       adv
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go && !act_zero) state_d = ST_FETCH;
      ST_FETCH: begin
        if (!go)            state_d = ST_IDLE;
        else if (ctl_valid) state_d = ctl_esc ? ST_ESC : ST_DATA;
      end
      ST_ESC:   if (tx_ready) state_d = ST_DATA;
      ST_DATA:  if (tx_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o   = state_q;
  assign fetch_req = (state_q == ST_FETCH);
  assign adv       = (state_q == ST_DATA) && tx_ready;

  // R9: abort while waiting for a control byte returns to idle
  a_r9_abort_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) && !go |=> (state_q == ST_IDLE));
endmodule

// File: rtl/txseq_top.sv
module txseq_top
  import txseq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int EXT_W  = 2,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int MODE_W = 3,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [EXT_W-1:0]  wr_ext,
  input  logic              ctl_valid,
  input  logic [CHAR_W-1:0] ctl_byte,
  input  logic              tx_ready,
  input  logic              chk_taken,
  input  logic              mem_nxm,
  input  logic              mem_perr,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        tx_kind,
  output logic [CHAR_W-1:0] esc_char,
  output logic [MODE_W-1:0] tx_mode,
  output logic              send_chk1,
  output logic              go,
  output logic              use_alt,
  output logic              err_nxm,
  output logic              err_perr
);
  localparam int NMODE_LSB = 4;

  // descriptor tables: index 0 principal, 1 alternate
  logic [1:0]        d_wr_addr, d_wr_cnt, d_adv, d_zero, d_last, d_normal;
  logic [ADDR_W-1:0] d_addr [2];

  seq_state_t state;
  logic       adv;

  logic              go_q, go_d, alt_q, alt_d;
  logic              imark_q, imark_d, chken_q, chken_d;
  logic [MODE_W-1:0] nmode_q, nmode_d, mode_q, mode_d;
  logic [CHAR_W-1:0] esc_q, esc_d, ctl_q, ctl_d;
  logic              chk1_q, chk1_d, nxm_q, nxm_d, perr_q, perr_d;

  logic act_zero, oth_zero, act_last, act_normal;
  logic wr_ctrl, wr_mode, wr_escr;
  logic expire, idle_flip, idle_empty;
  line_kind_t kind;

  generate
    for (genvar t = 0; t < 2; t++) begin : g_tbl
      assign d_wr_addr[t] = wr_en && (wr_sel == 3'(2 * t));
      assign d_wr_cnt[t]  = wr_en && (wr_sel == 3'(2 * t + 1));
      assign d_adv[t]     = adv && (alt_q == (t != 0));

      txseq_desc #(
        .ADDR_W(ADDR_W), .EXT_W(EXT_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
      ) i_desc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (d_wr_addr[t]),
        .wr_cnt   (d_wr_cnt[t]),
        .wr_data  (wr_data),
        .wr_ext   (wr_ext),
        .adv      (d_adv[t]),
        .addr_o   (d_addr[t]),
        .zero_o   (d_zero[t]),
        .last_o   (d_last[t]),
        .normal_o (d_normal[t])
      );
    end
  endgenerate

  assign act_zero   = d_zero[alt_q];
  assign oth_zero   = d_zero[~alt_q];
  assign act_last   = d_last[alt_q];
  assign act_normal = d_normal[alt_q];

  txseq_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_q),
    .act_zero  (act_zero),
    .ctl_valid (ctl_valid),
    .ctl_esc   (ctl_byte[1]),
    .tx_ready  (tx_ready),
    .state_o   (state),
    .fetch_req (fetch_req),
    .adv       (adv)
  );

  assign wr_ctrl    = wr_en && (wr_sel == SEL_CTRL);
  assign wr_mode    = wr_en && (wr_sel == SEL_MODE);
  assign wr_escr    = wr_en && (wr_sel == SEL_ESC);
  assign expire     = adv && act_last;
  assign idle_flip  = (state == ST_IDLE) && go_q && act_zero && !oth_zero;
  assign idle_empty = (state == ST_IDLE) && go_q && act_zero && oth_zero;

  always_comb begin
    go_d    = go_q;
    alt_d   = alt_q;
    imark_d = imark_q;
    chken_d = chken_q;
    nmode_d = nmode_q;
    mode_d  = mode_q;
    esc_d   = esc_q;
    ctl_d   = ctl_q;
    chk1_d  = chk1_q;
    nxm_d   = nxm_q;
    perr_d  = perr_q;

    if (expire || idle_flip) alt_d = ~alt_q;
    if (wr_ctrl) begin
      go_d    = wr_data[0];
      alt_d   = wr_data[1];
      imark_d = wr_data[2];
      chken_d = wr_data[3];
      nmode_d = wr_data[NMODE_LSB +: MODE_W];
      nxm_d   = 1'b0;
      perr_d  = 1'b0;
    end
    if (mem_nxm)  nxm_d  = 1'b1;
    if (mem_perr) perr_d = 1'b1;
    if (mem_nxm || mem_perr || (expire && oth_zero) || idle_empty) go_d = 1'b0;

    if (expire && !act_normal) mode_d = nmode_q;
    if (wr_mode) mode_d = wr_data[MODE_W-1:0];
    if (wr_escr) esc_d = wr_data[CHAR_W-1:0];

    if ((state == ST_FETCH) && ctl_valid) ctl_d = ctl_byte;

    if (chk_taken) chk1_d = 1'b0;
    if ((adv && ctl_q[3]) || (expire && !act_normal && chken_q)) chk1_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q    <= 1'b0;
      alt_q   <= 1'b0;
      imark_q <= 1'b0;
      chken_q <= 1'b0;
      nmode_q <= '0;
      mode_q  <= '0;
      esc_q   <= '0;
      ctl_q   <= '0;
      chk1_q  <= 1'b0;
      nxm_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      go_q    <= go_d;
      alt_q   <= alt_d;
      imark_q <= imark_d;
      chken_q <= chken_d;
      nmode_q <= nmode_d;
      mode_q  <= mode_d;
      esc_q   <= esc_d;
      ctl_q   <= ctl_d;
      chk1_q  <= chk1_d;
      nxm_q   <= nxm_d;
      perr_q  <= perr_d;
    end
  end

  always_comb begin
    unique case (state)
      ST_DATA: kind = K_DATA;
      ST_ESC:  kind = K_ESC;
      default: kind = (imark_q && d_zero[0] && d_zero[1]) ? K_MARK : K_SYNC;
    endcase
  end

  assign tx_kind    = kind;
  assign fetch_addr = d_addr[alt_q];
  assign esc_char   = esc_q;
  assign tx_mode    = mode_q;
  assign send_chk1  = chk1_q;
  assign go         = go_q;
  assign use_alt    = alt_q;
  assign err_nxm    = nxm_q;
  assign err_perr   = perr_q;

  // R4: an expiring count flips the table unless the host overrides it
  a_r4_switch: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !wr_ctrl |=> (alt_q != $past(alt_q)));
  // R5: nothing left in either table stops transmission
  a_r5_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
    expire && oth_zero |=> !go_q);
  // R6: a normal count keeps the mode on expiry
  a_r6_normal_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    expire && act_normal && !wr_mode |=> $stable(mode_q));
  // R8: the escape slot leaves the descriptor where it was
  a_r8_esc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ESC) && !wr_en |=> $stable(fetch_addr));
  // R10: a memory error stops the line and is recorded
  a_r10_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    mem_nxm || mem_perr |=> !go_q && (nxm_q || perr_q));
endmodule

// File: tb/test_txseq_top.sv
module test_txseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data;
  logic [1:0]  wr_ext;
  logic        ctl_valid;
  logic [7:0]  ctl_byte;
  logic        tx_ready, chk_taken, mem_nxm, mem_perr;
  logic        fetch_req;
  logic [17:0] fetch_addr;
  logic [1:0]  tx_kind;
  logic [7:0]  esc_char;
  logic [2:0]  tx_mode;
  logic        send_chk1, go, use_alt, err_nxm, err_perr;

  int n_chk = 0;
  int n_err = 0;

  txseq_top i_txseq_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_ext(wr_ext), .ctl_valid(ctl_valid), .ctl_byte(ctl_byte), .tx_ready(tx_ready),
    .chk_taken(chk_taken), .mem_nxm(mem_nxm), .mem_perr(mem_perr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .tx_kind(tx_kind),
    .esc_char(esc_char), .tx_mode(tx_mode), .send_chk1(send_chk1), .go(go),
    .use_alt(use_alt), .err_nxm(err_nxm), .err_perr(err_perr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data, input logic [1:0] ext);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data; wr_ext = ext;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fetch(input string req);
    for (int i = 0; i < 50 && !fetch_req; i++) @(negedge clk);
    chk({req, " fetch request"}, fetch_req, 1);
  endtask

  task automatic send_char(input logic [7:0] ctl, input logic [17:0] exp_addr,
                           input logic esc, input string req);
    wait_fetch(req);
    chk({req, " fetch address"}, fetch_addr, exp_addr);
    ctl_valid = 1'b1; ctl_byte = ctl;
    @(negedge clk);
    ctl_valid = 1'b0;
    if (esc) begin
      chk("R8 escape offered", tx_kind, 2);
      chk("R8 escape char", esc_char, 8'hA5);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      chk("R8 address held over escape", fetch_addr, exp_addr);
    end
    chk({req, " data offered"}, tx_kind, 3);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 go", go, 0);
    chk("R1 use_alt", use_alt, 0);
    chk("R1 send_chk1", send_chk1, 0);
    chk("R1 errors", {err_nxm, err_perr}, 0);
    chk("R1 mode", tx_mode, 0);
    chk("R1 fetch_req", fetch_req, 0);
    chk("R1 kind", tx_kind, 0);
  endtask

  task automatic t_principal_run;
    wr(3'd0, 16'h1234, 2'd1);
    wr(3'd1, 16'hFFFD, 2'd0);
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk("R12 idle tx_ready keeps address", fetch_addr, 18'h11234);
    wr(3'd7, 16'hFFFF, 2'd3);
    chk("R2 select 7 ignored", fetch_addr, 18'h11234);
    wr(3'd4, 16'h0001, 2'd0);
    send_char(8'h00, 18'h11234, 1'b0, "R2");
    chk("R3 go after first", go, 1);
    chk("R3 table after first", use_alt, 0);
    send_char(8'h00, 18'h11235, 1'b0, "R3");
    send_char(8'h00, 18'h11236, 1'b0, "R3");
    chk("R4 principal expiry selects alternate", use_alt, 1);
    chk("R5 go cleared when both empty", go, 0);
    chk("R5 sync idle without idle-mark", tx_kind, 0);
    chk("R6 normal expiry keeps mode", tx_mode, 0);
  endtask

  task automatic t_marked_pingpong;
    wr(3'd0, 16'h0100, 2'd0);
    wr(3'd1, 16'h7FFE, 2'd0);
    wr(3'd2, 16'h0200, 2'd3);
    wr(3'd3, 16'hFFFF, 2'd0);
    wr(3'd5, 16'h0002, 2'd0);
    chk("R2 mode write", tx_mode, 2);
    wr(3'd4, 16'h005D, 2'd0);
    send_char(8'h00, 18'h00100, 1'b0, "R3");
    chk("R6 mode before expiry", tx_mode, 2);
    send_char(8'h00, 18'h00101, 1'b0, "R3");
    chk("R6 marked expiry loads next mode", tx_mode, 5);
    chk("R6 marked expiry raises check flag", send_chk1, 1);
    chk("R4 switched to alternate", use_alt, 1);
    chk("R4 go kept with alternate pending", go, 1);
    chk_taken = 1'b1; @(negedge clk); chk_taken = 1'b0;
    chk("R7 chk_taken clears flag", send_chk1, 0);
    send_char(8'h00, 18'h30200, 1'b0, "R4");
    chk("R6 normal expiry keeps mode", tx_mode, 5);
    chk("R6 normal expiry no check flag", send_chk1, 0);
    chk("R4 alternate expiry selects principal", use_alt, 0);
    chk("R5 go cleared", go, 0);
    chk("R5 mark idle", tx_kind, 1);
  endtask

  task automatic t_escape_check;
    wr(3'd6, 16'h00A5, 2'd0);
    wr(3'd0, 16'h0400, 2'd0);
    wr(3'd1, 16'hFFFE, 2'd0);
    wr(3'd4, 16'h0001, 2'd0);
    wait_fetch("R12");
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    chk("R12 tx_ready in fetch keeps request", fetch_req, 1);
    chk("R12 tx_ready in fetch keeps address", fetch_addr, 18'h00400);
    send_char(8'h02, 18'h00400, 1'b1, "R8");
    chk("R8 one advance after escape", fetch_addr, 18'h00401);
    chk("R7 no flag without bit 3", send_chk1, 0);
    send_char(8'h08, 18'h00401, 1'b0, "R7");
    chk("R7 control bit 3 raises flag", send_chk1, 1);
    chk_taken = 1'b1; @(negedge clk); chk_taken = 1'b0;
    chk("R7 flag cleared", send_chk1, 0);
  endtask

  task automatic t_abort;
    wr(3'd0, 16'h0800, 2'd0);
    wr(3'd1, 16'hFFFB, 2'd0);
    wr(3'd4, 16'h0001, 2'd0);
    wait_fetch("R9");
    wr(3'd4, 16'h0000, 2'd0);
    @(negedge clk);
    chk("R9 fetch dropped after abort", fetch_req, 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R9 no fetch later", fetch_req, 0);
    chk("R9 address unchanged", fetch_addr, 18'h00800);
    wr(3'd4, 16'h0001, 2'd0);
    wait_fetch("R9");
    ctl_valid = 1'b1; ctl_byte = 8'h00;
    @(negedge clk);
    ctl_valid = 1'b0;
    wr_en = 1'b1; wr_sel = 3'd4; wr_data = 16'h0000; tx_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_ready = 1'b0;
    chk("R9 character in flight completes", fetch_addr, 18'h00801);
    chk("R9 go off", go, 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R9 no fetch after completion", fetch_req, 0);
  endtask

  task automatic t_errors;
    wr(3'd4, 16'h0001, 2'd0);
    wait_fetch("R10");
    mem_nxm = 1'b1; @(negedge clk); mem_nxm = 1'b0;
    chk("R10 nxm clears go", go, 0);
    chk("R10 nxm flag", err_nxm, 1);
    @(negedge clk);
    chk("R10 fetch stops", fetch_req, 0);
    mem_perr = 1'b1; @(negedge clk); mem_perr = 1'b0;
    chk("R10 parity flag", err_perr, 1);
    wr(3'd4, 16'h0000, 2'd0);
    chk("R10 control write clears flags", {err_nxm, err_perr}, 0);
  endtask

  task automatic t_start_switch;
    wr(3'd1, 16'h8000, 2'd0);
    wr(3'd2, 16'h0300, 2'd0);
    wr(3'd3, 16'hFFFF, 2'd0);
    wr(3'd4, 16'h0001, 2'd0);
    wait_fetch("R11");
    chk("R11 switched to alternate", use_alt, 1);
    send_char(8'h00, 18'h00300, 1'b0, "R11");
    chk("R11 done, back to principal", use_alt, 0);
    chk("R11 go cleared", go, 0);
    wr(3'd4, 16'h0005, 2'd0);
    @(negedge clk);
    chk("R5 go with both empty clears", go, 0);
    chk("R5 mark when empty", tx_kind, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; wr_ext = '0;
    ctl_valid = 1'b0; ctl_byte = '0; tx_ready = 1'b0; chk_taken = 1'b0;
    mem_nxm = 1'b0; mem_perr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_principal_run();
    t_marked_pingpong();
    t_escape_check();
    t_abort();
    t_errors();
    t_start_switch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule